// File: doc/BRIEF.md
# Processor I/O Port with Floating-Bit Decay

This block sits between an 8-bit processor and its memory. It claims the two lowest addresses of the processor bus. Address 0 holds a direction register, where a 1 in a bit makes that pin an output. Address 1 holds the output data register and returns the port value when read. Every other access is passed to an external RAM port unchanged. The block also keeps a model of the external pin levels, and from the direction and data registers it drives a 3-bit bank-select code to the memory decoder.

The two high port bits, 6 and 7, have no pull-up. When such a bit is an input, it returns a stored level that was captured the last time it was charged. Each of the two bits has a small decay cell with two states. `CELL_HOLD` means no timer is running. `CELL_DECAY` means a deadline is pending. A charge event takes the cell from either state into `CELL_DECAY`, and a second charge restarts the timer. A read of address 1 made after the deadline takes `CELL_DECAY` back to `CELL_HOLD` and clears the stored level. There is no other transition.

Time comes from a free-running cycle counter `CNT_W` bits wide. Deadlines are compared through a wrap-safe signed difference, so `FALLOFF` must be smaller than 2^(CNT_W-1).

Top module: `cpuport_decay`

## Requirements
- R1: An access to address 0 reads or writes the direction register. An access to address 1 reads the port value or writes the data register. A read of address 0 or 1 does not assert `ram_en`. Any other access asserts `ram_en` with the same address, write flag and write byte, and a read returns `ram_rdata` on `acc_rdata` in the same cycle.
- R2: After reset the direction register is 0x00 and the data register is 0x3F. `bank_sel` is 7 and a read of address 1 returns 0x1F.
- R3: After each register write, every output pin (direction bit 1) takes the data bit. Every input pin keeps its previous modelled level.
- R4: A read of address 1 returns (data OR NOT dir) AND (pins OR 0x17). Bit 5 is forced to 0 while direction bit 5 is 0. Bits 6 and 7 are replaced by their stored level while their direction bit is 0.
- R5: `bank_sel` equals bits 2..0 of (data OR NOT dir), as held after the last write.
- R6: A data write charges bit 6 or 7 only when that bit's direction is 1. The stored level becomes the written bit and a new deadline is set to the current cycle plus `FALLOFF`. When the direction bit is 0, the write leaves the stored level unchanged.
- R7: A direction write that turns bit 6 or 7 from 1 to 0 charges that bit. The stored level becomes the current data bit and the deadline restarts at the current cycle plus `FALLOFF`.
- R8: A read of address 1 in a cycle strictly later than a pending deadline returns 0 for that stored level. The same read clears the level and ends the timer. A read in the deadline cycle itself still returns the stored level.
- R9: A write to address 0 or 1 also asserts `ram_en` and `ram_we` for the same address, with `ram_wdata` taken from `last_bus_rd` instead of the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access in this cycle |
| acc_we | input | 1 | Access is a write |
| acc_addr | input | ADDR_W | Bus address |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte (combinational) |
| last_bus_rd | input | 8 | Byte of the most recent bus read |
| bank_sel | output | 3 | Bank-select code to the memory decoder |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write flag |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte |

## Verification
`acc_rdata` and every `ram_*` output are due in the cycle of the access itself. Register writes, pin levels and `bank_sel` change at the clock edge that ends the write and are due from the following cycle. The bench drives each access at the falling edge and checks the combinational results one time unit later. It checks `bank_sel` at each falling edge against the model state left by the previous edge. To pin the decay boundary to the exact cycle, the bench reads address 1 in every cycle across the deadline while keeping its own copy of the cycle counter. It uses an 8-bit counter, so the counter wraps many times during the run.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;
    typedef enum logic {
        CELL_HOLD  = 1'b0,
        CELL_DECAY = 1'b1
    } cell_state_e;

    localparam int PORT_W    = 8;
    localparam int BANK_W    = 3;
    localparam int FLOAT_LO  = 6;
    localparam int FLOAT_N   = 2;
    localparam logic [PORT_W-1:0] PULL_MASK  = 8'h17;
    localparam logic [PORT_W-1:0] DIR_RST    = 8'h00;
    localparam logic [PORT_W-1:0] DATA_RST   = 8'h3F;
    localparam logic [PORT_W-1:0] PINS_RST   = 8'h3F;
endpackage

// File: rtl/cpuport_regs.sv
module cpuport_regs
    import cpuport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dir,
    input  logic              wr_data,
    input  logic [PORT_W-1:0] wbyte,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] data_q,
    output logic [PORT_W-1:0] pins_q
);
    logic [PORT_W-1:0] dir_d, data_d, pins_d;

    always_comb begin
        dir_d  = wr_dir  ? wbyte : dir_q;
        data_d = wr_data ? wbyte : data_q;
        pins_d = (pins_q & ~dir_d) | (data_d & dir_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= DIR_RST;
            data_q <= DATA_RST;
            pins_q <= PINS_RST;
        end else begin
            dir_q  <= dir_d;
            data_q <= data_d;
            pins_q <= pins_d;
        end
    end

    // R1
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

    // R3
    pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dir || wr_data) |=> $stable(pins_q));

    // R3
    pins_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir || wr_data) |=> ((pins_q & dir_q) == (data_q & dir_q)));
endmodule

// File: rtl/cpuport_decay_cell.sv
module cpuport_decay_cell
    import cpuport_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int FALLOFF = 350000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] now,
    input  logic             dir_bit,
    input  logic             data_bit,
    input  logic             wr_data,
    input  logic             wr_bit,
    input  logic             wr_dir,
    input  logic             new_dir_bit,
    input  logic             rd_port,
    output logic             level
);
    localparam logic [CNT_W-1:0] SPAN = CNT_W'(FALLOFF);

    cell_state_e       state_q, state_d;
    logic              latch_q;
    logic [CNT_W-1:0]  deadline_q;
    logic [CNT_W-1:0]  gap;
    logic              load_wr, load_dir, expire;

    assign load_wr  = wr_data && dir_bit;
    assign load_dir = wr_dir && dir_bit && !new_dir_bit;
    assign gap      = deadline_q - now;
    assign expire   = rd_port && (state_q == CELL_DECAY) && gap[CNT_W-1];
    assign level    = expire ? 1'b0 : latch_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_HOLD:  if (load_wr || load_dir) state_d = CELL_DECAY;
            CELL_DECAY: if (load_wr || load_dir) state_d = CELL_DECAY;
                        else if (expire)          state_d = CELL_HOLD;
            default:    state_d = CELL_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q    <= 1'b0;
            deadline_q <= '0;
        end else if (load_wr) begin
            latch_q    <= wr_bit;
            deadline_q <= now + SPAN;
        end else if (load_dir) begin
            latch_q    <= data_bit;
            deadline_q <= now + SPAN;
        end else if (expire) begin
            latch_q    <= 1'b0;
        end
    end

    // R8
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state_q == CELL_HOLD) && !latch_q);

    // R6
    hold_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !dir_bit) |=> $stable(latch_q));

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_dir |=> (latch_q == $past(data_bit)) && (state_q == CELL_DECAY));
endmodule

// File: rtl/cpuport_decay.sv
module cpuport_decay
    import cpuport_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 32,
    parameter int FALLOFF = 350000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic [7:0]        last_bus_rd,
    output logic [2:0]        bank_sel,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    logic [CNT_W-1:0]  now_q;
    logic              hit_dir, hit_dat, hit_low;
    logic              wr_dir, wr_dat, rd_dat;
    logic [PORT_W-1:0] dir_q, data_q, pins_q, port_val;
    logic [FLOAT_N-1:0] float_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    assign hit_dir = acc_en && (acc_addr == ADDR_W'(0));
    assign hit_dat = acc_en && (acc_addr == ADDR_W'(1));
    assign hit_low = hit_dir || hit_dat;
    assign wr_dir  = hit_dir && acc_we;
    assign wr_dat  = hit_dat && acc_we;
    assign rd_dat  = hit_dat && !acc_we;

    cpuport_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dir  (wr_dir),
        .wr_data (wr_dat),
        .wbyte   (acc_wdata),
        .dir_q   (dir_q),
        .data_q  (data_q),
        .pins_q  (pins_q)
    );

    for (genvar g = 0; g < FLOAT_N; g++) begin : g_float
        cpuport_decay_cell #(
            .CNT_W   (CNT_W),
            .FALLOFF (FALLOFF)
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .now         (now_q),
            .dir_bit     (dir_q[FLOAT_LO+g]),
            .data_bit    (data_q[FLOAT_LO+g]),
            .wr_data     (wr_dat),
            .wr_bit      (acc_wdata[FLOAT_LO+g]),
            .wr_dir      (wr_dir),
            .new_dir_bit (acc_wdata[FLOAT_LO+g]),
            .rd_port     (rd_dat),
            .level       (float_lvl[g])
        );
    end

    always_comb begin
        port_val = (data_q | ~dir_q) & (pins_q | PULL_MASK);
        if (!dir_q[5]) port_val[5] = 1'b0;
        for (int i = 0; i < FLOAT_N; i++) begin
            if (!dir_q[FLOAT_LO+i]) port_val[FLOAT_LO+i] = float_lvl[i];
        end
    end

    always_comb begin
        if (hit_dir)      acc_rdata = dir_q;
        else if (hit_dat) acc_rdata = port_val;
        else              acc_rdata = ram_rdata;
    end

    assign bank_sel  = BANK_W'(data_q | ~dir_q);
    assign ram_en    = acc_en && (!hit_low || acc_we);
    assign ram_we    = acc_we;
    assign ram_addr  = acc_addr;
    assign ram_wdata = hit_low ? last_bus_rd : acc_wdata;

    // R5
    bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dir || wr_dat) |=> $stable(bank_sel));

    // R9
    shadow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dir || wr_dat) |-> (ram_en && ram_we && ram_wdata == last_bus_rd));
endmodule

// File: tb/cpuport_decay_test.sv
module cpuport_decay_test;
    localparam int CLK_PER = 10;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int FO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    acc_wdata = '0, last_bus_rd = '0, ram_rdata = '0;
    logic [7:0]    acc_rdata, ram_wdata;
    logic [2:0]    bank_sel;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [CW-1:0] bnow;
    logic [7:0] m_dir, m_data, m_pins;
    logic [1:0] m_lat, m_fl;
    logic [CW-1:0] m_dl [2];

    always #(CLK_PER/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) bnow <= '0;
        else        bnow <= bnow + 1'b1;
    end

    cpuport_decay #(.ADDR_W(AW), .CNT_W(CW), .FALLOFF(FO)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .last_bus_rd(last_bus_rd), .bank_sel(bank_sel), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] base_val();
        logic [7:0] v;
        v = (m_data | ~m_dir) & (m_pins | 8'h17);
        if (!m_dir[5]) v[5] = 1'b0;
        return v;
    endfunction

    function automatic void upd_pins();
        m_pins = (m_pins & ~m_dir) | (m_data & m_dir);
    endfunction

    // one bus cycle: drive at falling edge, check, update model, advance
    task automatic step(input bit en, input bit we, input logic [AW-1:0] a,
                        input logic [7:0] d, input string tag);
        logic [7:0] exp_rd;
        logic [1:0] exp_lvl;
        bit low, exp_en;
        // R5
        check("R5", bank_sel, (m_data | ~m_dir) & 8'h07);
        acc_en = en; acc_we = we; acc_addr = a; acc_wdata = d;
        ram_rdata = 8'($urandom); last_bus_rd = 8'($urandom);
        #1;
        low = (a == 0) || (a == 1);
        for (int i = 0; i < 2; i++) begin
            logic [CW-1:0] gap;
            gap = m_dl[i] - bnow;
            exp_lvl[i] = (en && !we && a == 1 && m_fl[i] && gap[CW-1]) ? 1'b0 : m_lat[i];
        end
        if (en && !we) begin
            if (a == 0) exp_rd = m_dir;
            else if (a == 1) begin
                exp_rd = base_val();
                if (!m_dir[6]) exp_rd[6] = exp_lvl[0];
                if (!m_dir[7]) exp_rd[7] = exp_lvl[1];
            end else exp_rd = ram_rdata;
            check(tag, acc_rdata, exp_rd);
        end
        exp_en = en && (!low || we);
        // R1
        check("R1", ram_en, exp_en);
        if (exp_en) begin
            check("R1", ram_addr, a);
            check("R1", ram_we, we);
            // R9
            check(low ? "R9" : "R1", ram_wdata, low ? last_bus_rd : d);
        end
        if (en && !we && a == 1) begin
            for (int i = 0; i < 2; i++)
                if (m_fl[i] && !exp_lvl[i] && m_lat[i]) begin m_lat[i] = 0; m_fl[i] = 0; end
            for (int i = 0; i < 2; i++) begin
                logic [CW-1:0] gap;
                gap = m_dl[i] - bnow;
                if (m_fl[i] && gap[CW-1]) begin m_lat[i] = 0; m_fl[i] = 0; end
            end
        end
        if (en && we && a == 0) begin
            for (int i = 0; i < 2; i++)
                if (m_dir[6+i] && !d[6+i]) begin
                    m_lat[i] = m_data[6+i]; m_dl[i] = bnow + CW'(FO); m_fl[i] = 1;
                end
            m_dir = d; upd_pins();
        end
        if (en && we && a == 1) begin
            for (int i = 0; i < 2; i++)
                if (m_dir[6+i]) begin
                    m_lat[i] = d[6+i]; m_dl[i] = bnow + CW'(FO); m_fl[i] = 1;
                end
            m_data = d; upd_pins();
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        m_dir = 8'h00; m_data = 8'h3F; m_pins = 8'h3F;
        m_lat = 2'b00; m_fl = 2'b00; m_dl[0] = '0; m_dl[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2", bank_sel, 3'd7);
        step(1, 0, 16'd0, 8'h00, "R2");
        step(1, 0, 16'd1, 8'h00, "R2");

        // R3 input pins keep level: drive bit 3 low, then float it
        step(1, 1, 16'd0, 8'h08, "R3");
        step(1, 1, 16'd1, 8'h00, "R3");
        step(1, 1, 16'd0, 8'h00, "R3");
        step(1, 0, 16'd1, 8'h00, "R3");
        step(1, 1, 16'd0, 8'h08, "R3");
        step(1, 1, 16'd1, 8'h08, "R3");
        step(1, 1, 16'd0, 8'h00, "R3");
        step(1, 0, 16'd1, 8'h00, "R3");

        // R4 bit 5 masked when input, visible when output
        step(1, 1, 16'd1, 8'h20, "R4");
        step(1, 1, 16'd0, 8'h20, "R4");
        step(1, 0, 16'd1, 8'h00, "R4");

        // R7 charge via output->input, then R8 boundary read every cycle
        step(1, 1, 16'd0, 8'hC0, "R7");
        step(1, 1, 16'd1, 8'hC0, "R7");
        step(1, 1, 16'd0, 8'h00, "R7");
        step(1, 0, 16'd1, 8'h00, "R7");
        for (int k = 0; k < FO + 4; k++) step(1, 0, 16'd1, 8'h00, "R8");

        // R6 data write with bits 6/7 input leaves stored level
        step(1, 1, 16'd0, 8'h40, "R6");
        step(1, 1, 16'd1, 8'h40, "R6");
        step(1, 1, 16'd0, 8'h00, "R6");
        step(1, 1, 16'd1, 8'h00, "R6");
        step(1, 0, 16'd1, 8'h00, "R6");

        // R1 pass-through at other addresses
        step(1, 0, 16'd2, 8'h00, "R1");
        step(1, 1, 16'hFFFF, 8'hA5, "R1");
        step(0, 0, 16'd1, 8'h00, "R1");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [AW-1:0] a;
            sel = int'($urandom_range(0, 9));
            a = (sel < 4) ? AW'(0) : (sel < 8) ? AW'(1) : AW'($urandom);
            step($urandom_range(0, 5) != 0, $urandom_range(0, 2) == 0, a,
                 8'($urandom), "R4");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule